// File: doc/BRIEF.md
# Power-Sequencing Delay Counter Bank

This block holds one programmable countdown per power event of a power management unit: supply settle, oscillator settle, PLL lock, wake reset release, watchdog timeout, I/O supply on, and separate power-up and power-down delays for the central logic domain, two processor clusters and the graphics domain. That makes fourteen channels. Software writes a 32-bit count for each event through a simple register port. The sequencer that sits outside this block then pulses a per-channel start strobe. The channel loads its count, counts down on its time base and raises its done output when the count runs out.

The time base can be either of two single-cycle tick enables in the system clock domain. One is a fast tick from the main oscillator. The other is a slow tick from the low-frequency oscillator. A channel uses the slow tick only when both the low-frequency-select bit and the power-mode-enable bit of the mode register are 1. The power-mode-enable bit clears itself when the `pmode_exit` strobe reports that the unit has left power mode. A third mode bit records whether the unit is clocked from its PLL or from the oscillator. That bit is stored and read back, but it has no effect on counting.

Each channel is a three-state machine:
- **CH_IDLE**: the channel is not counting.
- **CH_RUN**: the channel is counting down.
- **CH_DONE**: the channel has expired and done is high.

The transitions are:
- **start**: any state goes to CH_RUN. The count is loaded and the time base is latched.
- **expire**: CH_RUN goes to CH_DONE on a selected tick while the count is zero.
- **clear**: CH_DONE goes to CH_IDLE on a write-1-to-clear of the channel's status bit.

Register word addresses:
- Addresses 0 to 13 are the count registers for channels 0 to 13.
- Address 16 is the mode register. Bit 0 is the low-frequency select, bit 1 is power-mode enable, and bit 2 is the source select.
- Address 17 is the status register. Bit k is done for channel k. Reads return the done bits, and writing 1 to a bit clears it.
- All other addresses read as 0.

Top module: `pwr_delay_bank`

## Requirements
- R1: After reset, every count register reads 0x00005DC0, the mode register reads 0 and all done outputs are 0.
- R2: A write to a count register (addresses 0..13) stores all 32 bits, and a read returns them unchanged.
- R3: A channel counts on `slow_tick` when mode bit 0 and mode bit 1 are both 1 at its start. Otherwise it counts on `fast_tick`.
- R4: A `pmode_exit` pulse clears mode bit 1 on the next edge, and it wins over a write to the mode register in the same cycle. Bits 0 and 2 are kept.
- R5: Mode bit 2 (source select) is stored and read back but does not change the time base.
- R6: A start loads the channel's count register value N. Done rises on the clock edge of the (N+1)-th selected tick after the start. A tick in the start cycle itself is not counted, so N=0 completes on the first tick after the start.
- R7: The time base is latched when a channel starts. Mode changes during a run do not affect that run.
- R8: Writing a channel's count register while it is running does not change the current run. The new value applies at the next start.
- R9: A start on a running or done channel reloads it and clears its done output on the next edge. A start wins over a clear in the same cycle.
- R10: Done stays high until the channel is started again or a 1 is written to its bit of the status register (address 17). Writing 0 to the bit leaves it set.
- R11: Channels are independent. A start, expiry or clear on one channel never changes another channel's done output.
- R12: Reading address 17 returns the done vector in bits 13..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write enable |
| addr | input | 5 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| fast_tick | input | 1 | Fast time-base tick enable |
| slow_tick | input | 1 | Slow time-base tick enable |
| pmode_exit | input | 1 | Pulse reporting that the unit left power mode |
| start | input | 14 | Per-channel start strobes |
| done | output | 14 | Per-channel expiry flags |

## Verification
A wrong internal state in this block shows up at the ports in one of three ways:
- a count that is off by one, or counting on the wrong time base, moves the done edge by at least one tick;
- a stale latched count or time base makes the done edge late or early;
- a missed clear or reload leaves done high when it should be low.

The bench's reference model predicts the done vector and the read data on every clock. A divergence is therefore reported in the same cycle it appears at the outputs. Short counts on both time bases, restarts, mid-run rewrites and the full reset count keep every channel-state path within reach of that comparison.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

    localparam int MODE_LF_BIT  = 0;
    localparam int MODE_PM_BIT  = 1;
    localparam int MODE_SRC_BIT = 2;
    localparam int MODE_W       = 3;

    localparam logic [31:0] CNT_RESET_VAL = 32'h0000_5DC0;

    localparam int CH_SUPPLY_OK   = 0;
    localparam int CH_OSC_SETTLE  = 1;
    localparam int CH_PLL_LOCK    = 2;
    localparam int CH_WAKE_RST    = 3;
    localparam int CH_TIMEOUT     = 4;
    localparam int CH_IO_ON       = 5;
    localparam int CH_CORE_UP     = 6;
    localparam int CH_CORE_DN     = 7;
    localparam int CH_CLA_UP      = 8;
    localparam int CH_CLA_DN      = 9;
    localparam int CH_CLB_UP      = 10;
    localparam int CH_CLB_DN      = 11;
    localparam int CH_GFX_UP      = 12;
    localparam int CH_GFX_DN      = 13;
    localparam int CH_COUNT       = 14;

endpackage

// File: rtl/pdb_regs.sv
module pdb_regs
    import pdb_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [CNT_W-1:0]               wdata,
    input  logic                           pmode_exit,
    input  logic [NUM_CH-1:0]              status_in,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cnt_cfg,
    output logic [MODE_W-1:0]              mode_q,
    output logic [NUM_CH-1:0]              clr_mask,
    output logic [CNT_W-1:0]               rdata
);

    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(2 ** (ADDR_W - 1));
    localparam logic [ADDR_W-1:0] STAT_ADDR = MODE_ADDR + ADDR_W'(1);

    // Count registers, one per channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_cfg[g] <= CNT_W'(CNT_RESET_VAL);
            end else if (wr_en && (addr == ADDR_W'(g))) begin
                cnt_cfg[g] <= wdata;
            end
        end
    end

    // Mode register; leaving power mode overrides a same-cycle write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            if (wr_en && (addr == MODE_ADDR)) begin
                mode_q <= wdata[MODE_W-1:0];
            end
            if (pmode_exit) begin
                mode_q[MODE_PM_BIT] <= 1'b0;
            end
        end
    end

    always_comb begin
        clr_mask = '0;
        if (wr_en && (addr == STAT_ADDR)) begin
            clr_mask = wdata[NUM_CH-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = cnt_cfg[i];
            end
        end
        if (addr == MODE_ADDR) begin
            rdata = {{(CNT_W-MODE_W){1'b0}}, mode_q};
        end
        if (addr == STAT_ADDR) begin
            rdata = {{(CNT_W-NUM_CH){1'b0}}, status_in};
        end
    end

endmodule

// File: rtl/pdb_timebase.sv
module pdb_timebase
    import pdb_pkg::*;
(
    input  logic              lf_sel,
    input  logic              pm_en,
    output logic              slow_sel
);

    // Slow base only inside power mode with low-frequency selected
    always_comb begin
        slow_sel = lf_sel & pm_en;
    end

endmodule

// File: rtl/pdb_channel.sv
module pdb_channel
    import pdb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             clr,
    input  logic [CNT_W-1:0] load_val,
    input  logic             slow_sel,
    input  logic             fast_tick,
    input  logic             slow_tick,
    output logic             done
);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             use_slow_q;
    logic             tick;

    always_comb begin
        tick    = use_slow_q ? slow_tick : fast_tick;
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: state_d = CH_IDLE;
            CH_RUN:  if (tick && (cnt_q == '0)) state_d = CH_DONE;
            CH_DONE: if (clr) state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
        if (start) begin
            state_d = CH_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= CH_IDLE;
            cnt_q      <= '0;
            use_slow_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                cnt_q      <= load_val;
                use_slow_q <= slow_sel;
            end else if ((state_q == CH_RUN) && tick && (cnt_q != '0)) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    always_comb begin
        done = (state_q == CH_DONE);
    end

endmodule

// File: rtl/pwr_delay_bank.sv
module pwr_delay_bank
    import pdb_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              pmode_exit,
    input  logic [NUM_CH-1:0] start,
    output logic [NUM_CH-1:0] done
);

    logic [NUM_CH-1:0][CNT_W-1:0] cnt_cfg;
    logic [MODE_W-1:0]            mode_q;
    logic [NUM_CH-1:0]            clr_mask;
    logic                         slow_sel;

    pdb_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .pmode_exit (pmode_exit),
        .status_in  (done),
        .cnt_cfg    (cnt_cfg),
        .mode_q     (mode_q),
        .clr_mask   (clr_mask),
        .rdata      (rdata)
    );

    pdb_timebase u_tb (
        .lf_sel   (mode_q[MODE_LF_BIT]),
        .pm_en    (mode_q[MODE_PM_BIT]),
        .slow_sel (slow_sel)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pdb_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start[g]),
            .clr       (clr_mask[g]),
            .load_val  (cnt_cfg[g]),
            .slow_sel  (slow_sel),
            .fast_tick (fast_tick),
            .slow_tick (slow_tick),
            .done      (done[g])
        );
    end

endmodule

// File: rtl/pwr_delay_bank_chk.sv
module pwr_delay_bank_chk #(
    parameter int NUM_CH = 14,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic              fast_tick,
    input logic              slow_tick,
    input logic              pmode_exit,
    input logic              pm_en,
    input logic [NUM_CH-1:0] start,
    input logic [NUM_CH-1:0] done
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(2 ** (ADDR_W - 1) + 1);

    logic stat_wr;
    assign stat_wr = wr_en && (addr == STAT_ADDR);

    // R4
    pm_exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pmode_exit |=> !pm_en);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_k
        // R10
        done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done[k] && !start[k] && !(stat_wr && wdata[k])) |=> done[k]);
        // R10
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done[k] && !start[k] && stat_wr && wdata[k]) |=> !done[k]);
        // R9
        start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start[k] |=> !done[k]);
        // R6
        rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done[k]) |-> $past(fast_tick || slow_tick));
    end

endmodule

bind pwr_delay_bank pwr_delay_bank_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .fast_tick  (fast_tick),
    .slow_tick  (slow_tick),
    .pmode_exit (pmode_exit),
    .pm_en      (mode_q[1]),
    .start      (start),
    .done       (done)
);

// File: tb/tb_pwr_delay_bank.sv
module tb_pwr_delay_bank;

    localparam int NCH = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fast_tick = 1'b0;
    logic        slow_tick = 1'b0;
    logic        pmode_exit = 1'b0;
    logic [NCH-1:0] start = '0;
    logic [NCH-1:0] done;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    pwr_delay_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .pmode_exit(pmode_exit), .start(start), .done(done)
    );

    // Reference model state
    logic [31:0] m_reg [NCH];
    logic [31:0] m_cnt [NCH];
    int          m_st  [NCH];   // 0 idle, 1 running, 2 expired
    bit          m_slow[NCH];
    logic [2:0]  m_mode;

    function automatic logic [NCH-1:0] m_done();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i] = (m_st[i] == 2);
        return v;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        if (a < 5'(NCH)) return m_reg[a];
        if (a == 5'd16) return {29'd0, m_mode};
        if (a == 5'd17) return {18'd0, m_done()};
        return 32'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Tick generators: fast every 2 cycles, slow every 9 cycles
    always @(negedge clk) begin
        cyc++;
        fast_tick = (cyc % 2 == 0);
        slow_tick = (cyc % 9 == 0);
    end

    // Model update and per-cycle comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_reg[i] = 32'h5DC0; m_cnt[i] = 0; m_st[i] = 0; m_slow[i] = 0;
            end
            m_mode = 0;
        end else begin
            bit sel;
            sel = m_mode[0] & m_mode[1];
            for (int i = 0; i < NCH; i++) begin
                bit t;
                t = m_slow[i] ? slow_tick : fast_tick;
                if (start[i]) begin
                    m_st[i] = 1; m_cnt[i] = m_reg[i]; m_slow[i] = sel;
                end else if (m_st[i] == 1 && t) begin
                    if (m_cnt[i] == 0) m_st[i] = 2;
                    else m_cnt[i] = m_cnt[i] - 1;
                end else if (m_st[i] == 2 && wr_en && addr == 5'd17 && wdata[i]) begin
                    m_st[i] = 0;
                end
            end
            if (wr_en) begin
                if (addr < 5'(NCH)) m_reg[addr] = wdata;
                if (addr == 5'd16) m_mode = wdata[2:0];
            end
            if (pmode_exit) m_mode[1] = 1'b0;
        end
        #1;
        // R6 R11: done vector matches the model every cycle
        chk(done == m_done(), "R6/R11 done vector", 32'(done), 32'(m_done()));
        // R2 R12: read data matches the model every cycle
        chk(rdata == m_read(addr), "R2/R12 rdata", rdata, m_read(addr));
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic go(input logic [NCH-1:0] m);
        @(negedge clk); start = m;
        @(negedge clk); start = '0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); addr = a; #3;
        chk(rdata == exp, req, rdata, exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_done(input int ch, input bit exp, input string req);
        @(negedge clk); #3;
        chk(done[ch] == exp, req, 32'(done[ch]), 32'(exp));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1;
        // R1 reset state
        rd(5'd0,  32'h5DC0, "R1 count reset ch0");
        rd(5'd13, 32'h5DC0, "R1 count reset ch13");
        rd(5'd16, 32'h0, "R1 mode reset");
        rd(5'd17, 32'h0, "R1 status reset");
        // R2 full-width readback
        wr(5'd3, 32'hA5A5_1234);
        rd(5'd3, 32'hA5A5_1234, "R2 readback");
        // R6 fast base, count 5 and count 0
        wr(5'd0, 32'd5);
        wr(5'd1, 32'd0);
        go(14'b11);
        wait_n(20);
        chk_done(0, 1, "R6 count 5 expired");
        chk_done(1, 1, "R6 count 0 expired");
        rd(5'd17, 32'h3, "R12 status shows done");
        // R10 write 0 keeps, write 1 clears only that bit (R11)
        wr(5'd17, 32'h0);
        chk_done(0, 1, "R10 write-0 keeps done");
        wr(5'd17, 32'h1);
        chk_done(0, 0, "R10 w1c clears");
        chk_done(1, 1, "R11 other channel unaffected");
        // R3 lf only -> fast
        wr(5'd16, 32'h1);
        wr(5'd2, 32'd3);
        go(14'b100);
        wait_n(12);
        chk_done(2, 1, "R3 lf without pm uses fast");
        // R3 lf and pm -> slow
        wr(5'd16, 32'h3);
        wr(5'd4, 32'd3);
        go(14'b1_0000);
        wait_n(12);
        chk_done(4, 0, "R3 slow base not yet expired");
        wait_n(40);
        chk_done(4, 1, "R3 slow base expired");
        // R5 source bit does not matter
        wr(5'd16, 32'h5);
        wr(5'd5, 32'd3);
        go(14'b10_0000);
        wait_n(12);
        chk_done(5, 1, "R5 source bit keeps fast");
        // R7 time base latched at start
        wr(5'd16, 32'h3);
        wr(5'd6, 32'd4);
        go(14'b100_0000);
        wr(5'd16, 32'h0);
        wait_n(12);
        chk_done(6, 0, "R7 run stays on slow base");
        wait_n(50);
        chk_done(6, 1, "R7 slow run completes");
        // R4 power-mode exit clears pm bit, wins over write
        wr(5'd16, 32'h7);
        @(negedge clk); pmode_exit = 1;
        @(negedge clk); pmode_exit = 0;
        rd(5'd16, 32'h5, "R4 exit clears pm bit");
        @(negedge clk); wr_en = 1; addr = 5'd16; wdata = 32'h3; pmode_exit = 1;
        @(negedge clk); wr_en = 0; pmode_exit = 0;
        rd(5'd16, 32'h1, "R4 exit wins over write");
        // R8 rewrite during run
        wr(5'd7, 32'd10);
        go(14'b1000_0000);
        wr(5'd7, 32'd1000);
        wait_n(24);
        chk_done(7, 1, "R8 run uses old count");
        rd(5'd7, 32'd1000, "R8 new value stored");
        // R9 restart done and busy channel
        wr(5'd7, 32'd20);
        go(14'b1000_0000);
        chk_done(7, 0, "R9 restart clears done");
        wait_n(20);
        go(14'b1000_0000);
        wait_n(20);
        chk_done(7, 0, "R9 reload on busy channel");
        wait_n(30);
        chk_done(7, 1, "R9 reloaded run completes");
        // R9 start wins over clear in same cycle
        @(negedge clk); wr_en = 1; addr = 5'd17; wdata = 32'h80; start = 14'h80;
        @(negedge clk); wr_en = 0; start = '0;
        chk_done(7, 0, "R9 start over clear");
        // R1 R6 reset count on fast base
        go(14'b1_0000_0000);
        wait_n(47990);
        chk_done(8, 0, "R6 reset count still running");
        wait_n(40);
        chk_done(8, 1, "R6 reset count expired");
        wait_n(4);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule